// File: doc/BRIEF.md
# Two-Port Register File with Mirrored Banks

This block holds the general-purpose registers of a small 16-bit processor. Two operands can be fetched in the same cycle through two independent read ports. One write port updates one register per clock. Each read port draws from its own private copy of the storage. Every write is sent to both copies, so the two copies never differ, and outside logic cannot tell this file from a single shared array.

Reads are combinational. A write takes effect at the rising clock edge. An active-low reset clears every register in both copies, so no simulation-only initial block is needed. All ports are plain control and data pins; nothing here streams, so there is no valid/ready handshake and no back-pressure.

Top module: `regfile_dualbank`

## Requirements
- R1: While reset is asserted and after it is released, every register reads 0 on both read ports until it is written.
- R2: When `wr_en` is 1 at a rising clock edge, register `wr_addr` takes `wr_data`, and both ports return it from the following cycle.
- R3: When `wr_en` is 0 at a rising edge, no register changes.
- R4: A read of the register being written in the same cycle returns the value held before that write.
- R5: The two read ports address independently, so two different registers are read in the same cycle.
- R6: Both ports return identical data whenever they present the same address, at all times, including after any sequence of writes.
- R7: A write changes only the addressed register; all other registers keep their values.
- R8: Reset asserted while a write is presented wins: the register reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of all registers |
| rd_addr_a | input | 3 | Register index for read port A |
| rd_data_a | output | 16 | Contents of register `rd_addr_a` (combinational) |
| rd_addr_b | input | 3 | Register index for read port B |
| rd_data_b | output | 16 | Contents of register `rd_addr_b` (combinational) |
| wr_en | input | 1 | Write enable, 1 = write at next rising edge |
| wr_addr | input | 3 | Register index to write |
| wr_data | input | 16 | Value to write |

## Verification
The bench builds the block with its default sizing of eight registers of sixteen bits. With only eight entries, several hundred random writes hit every register many times, and a full sweep of all sixty-four address pairs after the random phase proves the two banks still agree entry by entry. Sixteen-bit data makes random values distinct enough that a write landing in the wrong entry or bank shows up at once.

// File: rtl/regf_pkg.sv
package regf_pkg;
  localparam int unsigned REGF_DEF_ENTRIES = 8;
  localparam int unsigned REGF_DEF_WIDTH   = 16;
  localparam int unsigned REGF_NUM_BANKS   = 2;
endpackage

// File: rtl/regf_wr_decode.sv
module regf_wr_decode #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  output logic [ENTRIES-1:0] wr_sel
);
  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_sel
      assign wr_sel[g] = wr_en && (wr_addr == AW'(g));
    end
  endgenerate

  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
  p_sel_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (wr_sel == '0));
endmodule

// File: rtl/regf_bank.sv
module regf_bank #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned WIDTH   = 16,
  localparam int unsigned AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] wr_sel,
  input  logic [WIDTH-1:0]   wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [WIDTH-1:0]   rd_data
);
  logic [WIDTH-1:0] store [ENTRIES];

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         store[g] <= '0;
        else if (wr_sel[g]) store[g] <= wr_data;
      end

      p_entry_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel[g] |=> (store[g] == $past(wr_data)));
      p_entry_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel[g] |=> $stable(store[g]));
    end
  endgenerate

  assign rd_data = store[rd_addr];
endmodule

// File: rtl/regfile_dualbank.sv
module regfile_dualbank #(
  parameter int unsigned ENTRIES = regf_pkg::REGF_DEF_ENTRIES,
  parameter int unsigned WIDTH   = regf_pkg::REGF_DEF_WIDTH,
  localparam int unsigned AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned NB = regf_pkg::REGF_NUM_BANKS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_addr_a,
  output logic [WIDTH-1:0] rd_data_a,
  input  logic [AW-1:0]    rd_addr_b,
  output logic [WIDTH-1:0] rd_data_b,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data
);
  logic [ENTRIES-1:0] wr_sel;
  logic [AW-1:0]      bank_addr [NB];
  logic [WIDTH-1:0]   bank_data [NB];

  assign bank_addr[0] = rd_addr_a;
  assign bank_addr[1] = rd_addr_b;

  regf_wr_decode #(.ENTRIES(ENTRIES)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_sel(wr_sel)
  );

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_bank
      regf_bank #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_addr(bank_addr[b]), .rd_data(bank_data[b])
      );
    end
  endgenerate

  assign rd_data_a = bank_data[0];
  assign rd_data_b = bank_data[1];

  p_ports_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));
  p_write_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == rd_addr_a) |=>
      ((rd_addr_a != $past(rd_addr_a)) || rd_data_a == $past(wr_data)));
endmodule

// File: tb/regfile_dualbank_bench.sv
module regfile_dualbank_bench;
  localparam int N = 8;
  localparam int W = 16;

  logic clk = 0, rst_n = 0;
  logic [2:0] ra = 0, rb = 0, wa = 0;
  logic [W-1:0] wd = 0, da, db;
  logic we = 0;
  logic [W-1:0] model [N];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  regfile_dualbank u_regfile_dualbank (
    .clk(clk), .rst_n(rst_n), .rd_addr_a(ra), .rd_data_a(da),
    .rd_addr_b(rb), .rd_data_b(db), .wr_en(we), .wr_addr(wa), .wr_data(wd)
  );

  function automatic logic [W-1:0] expect_of(input logic [2:0] a);
    return model[a];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, check reads before the edge, update model at the edge
  task automatic cyc(input bit e, input logic [2:0] w, input logic [W-1:0] d,
                     input logic [2:0] a, input logic [2:0] b, input string req);
    @(negedge clk);
    we = e; wa = w; wd = d; ra = a; rb = b;
    #2;
    chk(da === expect_of(a), req, da, expect_of(a));
    chk(db === expect_of(b), req, db, expect_of(b));
    @(posedge clk);
    if (e) model[w] = d;
    #1;
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        @(negedge clk);
        we = 0; ra = 3'(i); rb = 3'(j);
        #2;
        chk(da === model[i], req, da, model[i]);
        chk(db === model[j], req, db, model[j]);
        if (i == j) chk(da === db, "R6", da, db);
      end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) model[i] = '0;
    #35;
    // R1: reads zero during reset
    ra = 3; rb = 6; #2;
    chk(da === 0, "R1", da, 0);
    chk(db === 0, "R1", db, 0);
    @(negedge clk); rst_n = 1;
    sweep("R1");
    // R2 and R4: write then read, same-cycle read sees old value
    cyc(1, 3'd5, 16'hBEEF, 3'd5, 3'd5, "R4");
    cyc(0, 3'd0, 16'h0, 3'd5, 3'd5, "R2");
    cyc(1, 3'd5, 16'h1234, 3'd5, 3'd0, "R4");
    cyc(0, 3'd0, 16'h0, 3'd5, 3'd0, "R2");
    // R3: disabled write with data present
    cyc(0, 3'd2, 16'hFFFF, 3'd2, 3'd5, "R3");
    cyc(0, 3'd0, 16'h0, 3'd2, 3'd5, "R3");
    // R5 and R7: neighbours untouched, distinct reads
    cyc(1, 3'd7, 16'hA5A5, 3'd6, 3'd0, "R7");
    cyc(1, 3'd0, 16'h0001, 3'd7, 3'd6, "R5");
    cyc(0, 3'd0, 16'h0, 3'd0, 3'd7, "R5");
    // random phase
    for (int k = 0; k < 400; k++)
      cyc(1'($urandom), 3'($urandom), 16'($urandom), 3'($urandom),
          3'($urandom), "R2");
    sweep("R6");
    // R8: reset wins over a presented write
    @(negedge clk);
    we = 1; wa = 3'd4; wd = 16'h7777; rst_n = 0;
    @(posedge clk); #1;
    @(negedge clk); we = 0; rst_n = 1;
    for (int i = 0; i < N; i++) model[i] = '0;
    ra = 3'd4; rb = 3'd4; #2;
    chk(da === 0, "R8", da, 0);
    chk(db === 0, "R8", db, 0);
    sweep("R8");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule